// File: doc/BRIEF.md
# LCD Controller Power-Up Sequencer

This block brings a 240x320 TFT panel controller with 16-bit registers out of reset without software help. When the system reset is released it holds the panel's hardware reset low for a set number of clock cycles. It then drives chip select active and issues a fixed, ordered series of register writes. Each write is an index/value pair handed to a downstream bus interface over a request/acknowledge handshake.

Between groups of writes the sequencer pauses for capacitor discharge and supply settling. The pauses are given in milliseconds and converted to clock cycles from a clock-frequency parameter. Five analogue-supply settings arrive on input ports: booster factor, reference ratio, regulator gain, common-electrode swing and common-electrode high level. The block masks each one to its field width and packs it into the matching power-control word when that word is issued. After the display-on write is acknowledged, the block raises a done flag and stays idle until the next reset.

The FSM has four states. HWRST drives the panel reset. WRITE holds a request until it is acknowledged. PAUSE counts down a millisecond interval. FINISHED is terminal. The transitions are:
- HWRST→WRITE when the reset counter expires.
- WRITE→WRITE on acknowledge when the next write needs no pause.
- WRITE→PAUSE on acknowledge of a write that is followed by a pause.
- PAUSE→WRITE when the interval counter expires.
- WRITE→FINISHED on acknowledge of the last write.

Top module: `lcd_pwrup_seq`

## Requirements
- R1: After rst_n rises, lcd_rst_n_o stays low, cs_n_o stays high and wr_req_o stays low for exactly RST_CYCLES clock cycles. From then on lcd_rst_n_o is high and cs_n_o is low.
- R2: The first seven writes, as index=value in hex, are E3=3008, E7=0012, EF=1231, 10=0000, 11=0007, 12=0000, 13=0000.
- R3: Writes eight to thirteen are 10=(1090 OR step<<8), 11=(0220 OR ratio), 12=gain, 13=(swing<<8), 29=level, 2B=000C.
- R4: The last six writes are 50=0000, 51=00EF, 52=0000, 53=013F, 60=A700, and last 07=0133.
- R5: Only the low bits of each setting port are used: step 3 bits, ratio 3 bits, gain 4 bits, swing 5 bits, level 6 bits. Higher bits have no effect on any written value.
- R6: wr_req_o stays high with wr_idx_o and wr_val_o unchanged until wr_ack_i is sampled high. In the next cycle the following write is presented, or a pause or done begins. While wr_req_o is low, wr_idx_o and wr_val_o read zero.
- R7: The following pauses are inserted, each lasting ms*(CLK_HZ/1000) cycles with wr_req_o low:
  - 200 ms after the acknowledge of write 13=0000;
  - 50 ms after 11=(0220 OR ratio);
  - 50 ms after 12=gain;
  - 50 ms after 2B=000C.
- R8: wr_ack_i while wr_req_o is low has no effect on the sequence or its timing.
- R9: done_o rises in the cycle after the last acknowledge and then stays high with wr_req_o low until reset.
- R10: A reset in the middle of the sequence restarts it from the panel reset and the first write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_up_i | input | 8 | Booster factor setting (3 bits used) |
| ref_ratio_i | input | 8 | Reference ratio setting (3 bits used) |
| reg_gain_i | input | 8 | Regulator gain setting (4 bits used) |
| vcom_amp_i | input | 8 | Common-electrode swing (5 bits used) |
| vcomh_i | input | 8 | Common-electrode high level (6 bits used) |
| wr_ack_i | input | 1 | Downstream acknowledge of the current write |
| lcd_rst_n_o | output | 1 | Panel hardware reset, active low |
| cs_n_o | output | 1 | Panel chip select, active low |
| wr_req_o | output | 1 | Write request |
| wr_idx_o | output | 16 | Register index of the current write |
| wr_val_o | output | 16 | Register value of the current write |
| done_o | output | 1 | Sequence complete |

## Verification
A wrong step counter shows at the ports on the very next request: the index/value pair no longer matches the expected list. A wrong pause length or a missed handshake shifts every later write by at least one cycle. A cycle-level reference model compares all outputs on every clock, so either fault is reported in the cycle it first appears, not only at done. A stray acknowledge that leaks into the FSM shortens a pause or advances the step, and this too appears within one cycle.

// File: rtl/lcd_pwrup_pkg.sv
package lcd_pwrup_pkg;

    localparam int NUM_OPS     = 19;
    localparam int STEP_W      = $clog2(NUM_OPS);
    localparam int MAX_WAIT_MS = 200;

    typedef enum logic [1:0] {
        ST_HWRST,
        ST_WRITE,
        ST_PAUSE,
        ST_FINISHED
    } seq_state_e;

    typedef struct packed {
        logic [15:0] idx;
        logic [15:0] val;
        logic [7:0]  wait_ms;
    } seq_op_t;

endpackage

// File: rtl/lcd_delay_cnt.sv
module lcd_delay_cnt #(
    parameter int CNT_W    = 16,
    parameter int RST_LOAD = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             zero_o
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= CNT_W'(RST_LOAD);
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/lcd_op_table.sv
module lcd_op_table
    import lcd_pwrup_pkg::*;
(
    input  logic [STEP_W-1:0] step_i,
    input  logic [7:0]        step_up_i,
    input  logic [7:0]        ref_ratio_i,
    input  logic [7:0]        reg_gain_i,
    input  logic [7:0]        vcom_amp_i,
    input  logic [7:0]        vcomh_i,
    output seq_op_t           op_o,
    output logic              last_o
);

    logic [7:0] su_m, rr_m, rg_m, va_m, vh_m;

    always_comb begin
        su_m = step_up_i   & 8'h07;
        rr_m = ref_ratio_i & 8'h07;
        rg_m = reg_gain_i  & 8'h0F;
        va_m = vcom_amp_i  & 8'h1F;
        vh_m = vcomh_i     & 8'h3F;
    end

    function automatic seq_op_t mk(input logic [15:0] i, input logic [15:0] v,
                                   input logic [7:0] w);
        seq_op_t o;
        o.idx     = i;
        o.val     = v;
        o.wait_ms = w;
        return o;
    endfunction

    always_comb begin
        unique case (step_i)
            5'd0:    op_o = mk(16'h00E3, 16'h3008, 8'd0);
            5'd1:    op_o = mk(16'h00E7, 16'h0012, 8'd0);
            5'd2:    op_o = mk(16'h00EF, 16'h1231, 8'd0);
            5'd3:    op_o = mk(16'h0010, 16'h0000, 8'd0);
            5'd4:    op_o = mk(16'h0011, 16'h0007, 8'd0);
            5'd5:    op_o = mk(16'h0012, 16'h0000, 8'd0);
            5'd6:    op_o = mk(16'h0013, 16'h0000, 8'd200);
            5'd7:    op_o = mk(16'h0010, 16'h1090 | ({8'h00, su_m} << 8), 8'd0);
            5'd8:    op_o = mk(16'h0011, 16'h0220 | {8'h00, rr_m}, 8'd50);
            5'd9:    op_o = mk(16'h0012, {8'h00, rg_m}, 8'd50);
            5'd10:   op_o = mk(16'h0013, {va_m, 8'h00}, 8'd0);
            5'd11:   op_o = mk(16'h0029, {8'h00, vh_m}, 8'd0);
            5'd12:   op_o = mk(16'h002B, 16'h000C, 8'd50);
            5'd13:   op_o = mk(16'h0050, 16'h0000, 8'd0);
            5'd14:   op_o = mk(16'h0051, 16'h00EF, 8'd0);
            5'd15:   op_o = mk(16'h0052, 16'h0000, 8'd0);
            5'd16:   op_o = mk(16'h0053, 16'h013F, 8'd0);
            5'd17:   op_o = mk(16'h0060, 16'hA700, 8'd0);
            5'd18:   op_o = mk(16'h0007, 16'h0133, 8'd0);
            default: op_o = mk(16'h0000, 16'h0000, 8'd0);
        endcase
    end

    assign last_o = (step_i == STEP_W'(NUM_OPS - 1));

endmodule

// File: rtl/lcd_pwrup_seq.sv
module lcd_pwrup_seq
    import lcd_pwrup_pkg::*;
#(
    parameter int CLK_HZ     = 50_000_000,
    parameter int RST_CYCLES = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [7:0]  step_up_i,
    input  logic [7:0]  ref_ratio_i,
    input  logic [7:0]  reg_gain_i,
    input  logic [7:0]  vcom_amp_i,
    input  logic [7:0]  vcomh_i,
    input  logic        wr_ack_i,
    output logic        lcd_rst_n_o,
    output logic        cs_n_o,
    output logic        wr_req_o,
    output logic [15:0] wr_idx_o,
    output logic [15:0] wr_val_o,
    output logic        done_o
);

    localparam int CYC_PER_MS = (CLK_HZ / 1000 < 1) ? 1 : CLK_HZ / 1000;
    localparam int LOAD_MAX   = MAX_WAIT_MS * CYC_PER_MS + RST_CYCLES;
    localparam int CNT_W      = $clog2(LOAD_MAX + 1);

    seq_state_e        state_q;
    logic [STEP_W-1:0] step_q;
    seq_op_t           op;
    logic              op_last;
    logic              tmr_zero;
    logic              tmr_load;
    logic [CNT_W-1:0]  wait_load;

    lcd_op_table u_table (
        .step_i      (step_q),
        .step_up_i   (step_up_i),
        .ref_ratio_i (ref_ratio_i),
        .reg_gain_i  (reg_gain_i),
        .vcom_amp_i  (vcom_amp_i),
        .vcomh_i     (vcomh_i),
        .op_o        (op),
        .last_o      (op_last)
    );

    assign wait_load = CNT_W'(op.wait_ms) * CNT_W'(CYC_PER_MS) - CNT_W'(1);
    assign tmr_load  = (state_q == ST_WRITE) && wr_ack_i && (op.wait_ms != 8'd0);

    lcd_delay_cnt #(
        .CNT_W    (CNT_W),
        .RST_LOAD (RST_CYCLES - 1)
    ) u_delay (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (wait_load),
        .zero_o     (tmr_zero)
    );

    // State register and step pointer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HWRST;
            step_q  <= '0;
        end else begin
            unique case (state_q)
                ST_HWRST: begin
                    if (tmr_zero) state_q <= ST_WRITE;
                end
                ST_WRITE: begin
                    if (wr_ack_i) begin
                        if (op.wait_ms != 8'd0) begin
                            state_q <= ST_PAUSE;
                            step_q  <= step_q + 1'b1;
                        end else if (op_last) begin
                            state_q <= ST_FINISHED;
                        end else begin
                            step_q  <= step_q + 1'b1;
                        end
                    end
                end
                ST_PAUSE: begin
                    if (tmr_zero) state_q <= ST_WRITE;
                end
                ST_FINISHED: state_q <= ST_FINISHED;
                default:     state_q <= ST_HWRST;
            endcase
        end
    end

    // Outputs decoded from state
    always_comb begin
        lcd_rst_n_o = 1'b1;
        cs_n_o      = 1'b0;
        wr_req_o    = 1'b0;
        wr_idx_o    = 16'h0000;
        wr_val_o    = 16'h0000;
        done_o      = 1'b0;
        unique case (state_q)
            ST_HWRST: begin
                lcd_rst_n_o = 1'b0;
                cs_n_o      = 1'b1;
            end
            ST_WRITE: begin
                wr_req_o = 1'b1;
                wr_idx_o = op.idx;
                wr_val_o = op.val;
            end
            ST_PAUSE:    ;
            ST_FINISHED: done_o = 1'b1;
            default:     ;
        endcase
    end

endmodule

// File: rtl/lcd_pwrup_seq_chk.sv
module lcd_pwrup_seq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_ack_i,
    input logic        lcd_rst_n_o,
    input logic        cs_n_o,
    input logic        wr_req_o,
    input logic [15:0] wr_idx_o,
    input logic [15:0] wr_val_o,
    input logic        done_o
);

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req_o && !wr_ack_i) |=> (wr_req_o && $stable(wr_idx_o) && $stable(wr_val_o))); // R6

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_req_o |-> (wr_idx_o == 16'h0000 && wr_val_o == 16'h0000)); // R6

    AST_HWRST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !lcd_rst_n_o |-> (cs_n_o && !wr_req_o)); // R1

    AST_REQ_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req_o |-> (!cs_n_o && lcd_rst_n_o)); // R1

    AST_GAIN_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req_o && wr_idx_o == 16'h0012) |-> (wr_val_o[15:4] == 12'h000)); // R5

    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> done_o); // R9

    AST_DONE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !wr_req_o); // R9

    AST_DONE_AFTER_ON: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> ($past(wr_req_o && wr_ack_i) && $past(wr_idx_o) == 16'h0007)); // R4

endmodule

bind lcd_pwrup_seq lcd_pwrup_seq_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_ack_i    (wr_ack_i),
    .lcd_rst_n_o (lcd_rst_n_o),
    .cs_n_o      (cs_n_o),
    .wr_req_o    (wr_req_o),
    .wr_idx_o    (wr_idx_o),
    .wr_val_o    (wr_val_o),
    .done_o      (done_o)
);

// File: tb/lcd_pwrup_seq_tb.sv
module lcd_pwrup_seq_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int CLK_HZ     = 4000;
    localparam int CPM        = CLK_HZ / 1000;
    localparam int RST_CYC    = 5;
    localparam int WDOG       = 60000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  su, rr, rg, va, vh;
    logic        ack = 1'b0;
    logic        lcd_rst_n, cs_n, req, done;
    logic [15:0] idx, val;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;
    int runsel  = 1;

    lcd_pwrup_seq #(.CLK_HZ(CLK_HZ), .RST_CYCLES(RST_CYC)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .step_up_i(su), .ref_ratio_i(rr), .reg_gain_i(rg),
        .vcom_amp_i(va), .vcomh_i(vh), .wr_ack_i(ack),
        .lcd_rst_n_o(lcd_rst_n), .cs_n_o(cs_n), .wr_req_o(req),
        .wr_idx_o(idx), .wr_val_o(val), .done_o(done)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", tag, what, act, exp, cyc);
        end
    endtask

    // Behavioural reference model
    int qi[$];
    int qv[$];
    int qw[$];
    int mph, mcnt, mstep, wcnt, tick;
    bit prev_stray;

    task automatic add(input int i, input int v, input int w);
        qi.push_back(i); qv.push_back(v); qw.push_back(w);
    endtask

    task automatic build();
        int b, c, g, a, h;
        b = su & 7; c = rr & 7; g = rg & 15; a = va & 31; h = vh & 63;
        qi.delete(); qv.delete(); qw.delete();
        add('hE3, 'h3008, 0); add('hE7, 'h0012, 0); add('hEF, 'h1231, 0);
        add('h10, 0, 0); add('h11, 7, 0); add('h12, 0, 0); add('h13, 0, 200);
        add('h10, 'h1000 + b * 256 + 'h80 + 'h10, 0);
        add('h11, 'h220 + c, 50);
        add('h12, g, 50);
        add('h13, a * 256, 0); add('h29, h, 0); add('h2B, 'hC, 50);
        add('h50, 0, 0); add('h51, 'hEF, 0); add('h52, 0, 0); add('h53, 'h13F, 0);
        add('h60, 'hA700, 0); add('h07, 'h133, 0);
    endtask

    function automatic string grp(input int s);
        if (runsel == 2) return "R5";
        if (s < 7) return "R2";
        if (s < 13) return "R3";
        return "R4";
    endfunction

    always @(negedge clk) begin
        tick++;
        if (!rst_n) begin
            mph = 0; mcnt = RST_CYC; mstep = 0; wcnt = 0; prev_stray = 0;
            build();
            ack = 1'b0;
            check("R1", "lcd_rst_n in reset", int'(lcd_rst_n), 0);
            check("R1", "cs_n in reset", int'(cs_n), 1);
            check("R1", "req in reset", int'(req), 0);
            check("R9", "done in reset", int'(done), 0);
        end else begin
            check("R1", "lcd_rst_n", int'(lcd_rst_n), (mph != 0) ? 1 : 0);
            check("R1", "cs_n", int'(cs_n), (mph == 0) ? 1 : 0);
            if (mph == 2) check(prev_stray ? "R8" : "R7", "req in pause", int'(req), 0);
            else check("R6", "req", int'(req), (mph == 1) ? 1 : 0);
            check(mph == 1 ? grp(mstep) : "R6", "idx", int'(idx), (mph == 1) ? qi[mstep] : 0);
            check(mph == 1 ? grp(mstep) : "R6", "val", int'(val), (mph == 1) ? qv[mstep] : 0);
            check(prev_stray ? "R8" : "R9", "done", int'(done), (mph == 3) ? 1 : 0);
            if (mph == 1) begin
                ack = (wcnt >= (mstep % 3));
                prev_stray = 0;
            end else begin
                ack = ((tick % 5) == 0);
                prev_stray = ack;
            end
            case (mph)
                0: begin
                    mcnt--;
                    if (mcnt == 0) begin mph = 1; wcnt = 0; end
                end
                1: begin
                    if (ack) begin
                        wcnt = 0;
                        if (qw[mstep] > 0) begin
                            mph = 2; mcnt = qw[mstep] * CPM; mstep++;
                        end else if (mstep == qi.size() - 1) begin
                            mph = 3;
                        end else begin
                            mstep++;
                        end
                    end else begin
                        wcnt++;
                    end
                end
                2: begin
                    mcnt--;
                    if (mcnt == 0) mph = 1;
                end
                default: ;
            endcase
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == WDOG) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    task automatic release_rst();
        @(posedge clk); #1 rst_n = 1'b1;
    endtask

    task automatic apply_rst();
        @(posedge clk); #1 rst_n = 1'b0;
        repeat (3) @(posedge clk);
    endtask

    task automatic wait_done();
        while (!(rst_n && done)) @(negedge clk);
        repeat (12) @(negedge clk);
        check("R9", "done held", int'(done), 1);
        check("R9", "req after done", int'(req), 0);
    endtask

    initial begin
        su = 8'd6; rr = 8'h03; rg = 8'h0D; va = 8'h12; vh = 8'h0A;
        repeat (4) @(posedge clk);
        // Run 1: default settings
        runsel = 1;
        release_rst();
        wait_done();
        // Run 2: settings with upper bits set
        apply_rst();
        su = 8'hF9; rr = 8'hAC; rg = 8'h37; va = 8'hE5; vh = 8'h91;
        runsel = 2;
        release_rst();
        wait_done();
        // Run 3: reset during the long pause, then a full run
        apply_rst();
        su = 8'h02; rr = 8'h05; rg = 8'h09; va = 8'h1F; vh = 8'h3F;
        runsel = 3;
        release_rst();
        repeat (300) @(negedge clk);
        check("R10", "in pause before mid-run reset", int'(req), 0);
        apply_rst();
        release_rst();
        while (!req) @(negedge clk);
        check("R10", "first idx after restart", int'(idx), 'hE3);
        check("R10", "first val after restart", int'(val), 'h3008);
        wait_done();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule